// File: doc/BRIEF.md
# Commit-Protected Pin Mode Select Register

This block holds one mode bit per pin of an 8-pin port. A mode bit of 0 leaves the pin under software (general-purpose I/O) control; a 1 hands the pin to its alternate hardware function. The eight mode bits drive the port's pin multiplexers directly through `sel_out`.

Some pin positions, chosen by the `PROT_MASK` parameter, carry functions that must not be switched off by accident, such as debug pins. A write to the mode register changes such a bit only when two guards both allow it. The first guard is a lock that opens when a fixed 32-bit key is written to it. The second is a per-bit commit enable, and that enable can itself be written only while the lock is open. Unprotected bits take every write. The reset value of the mode register is a per-port parameter (`DFLT_SEL`), and protected positions normally reset to 1. Either of the two reset inputs restores these defaults.

The lock is a two-state machine. `LK_LOCKED` is the reset state. The transition `KEY_MATCH` is a write of the key to the lock offset, and it moves the machine to `LK_OPEN`. The transition `KEY_MISS` is a write of any other value to the lock offset, and it returns the machine to `LK_LOCKED` from either state. All other cycles hold the state.

Top module: `pin_mode_guard`

## Requirements
- R1: After reset, the mode register reads `DFLT_SEL`, which is 0x80 by default. The lock offset reads 1 and the commit offset reads 0x00.
- R2: The mode register sits at offset 0x420. A read there returns the 8 mode bits in bits 7:0, with bits 31:8 at zero. `sel_out` always equals the stored mode bits, where 1 means hardware function and 0 means software control.
- R3: A write to offset 0x420 stores bits outside `PROT_MASK` (bits 6:0 by default) whatever the lock and commit state.
- R4: A protected bit (bit 7 by default) takes a write only when the lock is open and that bit's commit enable is 1. Otherwise it keeps its old value.
- R5: A write of 0xC0DE5A17 to offset 0x520 opens the lock, and any other value written there closes it. A read of 0x520 returns 0 while the lock is open and 1 while it is closed.
- R6: The commit register at offset 0x524 takes writes only while the lock is open. Bit positions outside `PROT_MASK` always read 0.
- R7: Reads of any other offset return 0. Writes to any other offset change no register.
- R8: Asserting `por_n` low or `ext_rst_n` low, each on its own, restores the R1 state. A reset that falls in the same cycle as a mode write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sel_out | output | 8 | Mode bits sent to the pin multiplexers |

## Verification
The mode-register write can land in the same cycle as an external reset. The bench provokes this by holding a write of 0x00 to offset 0x420 on the bus while it pulls `ext_rst_n` low at the same clock edge. It then judges that `sel_out`, the lock and the commit register all show their defaults rather than the written data. A second interaction is tested as well: a relocking write followed at once by a protected write. That protected write must be refused even though its commit enable is still set.

// File: rtl/pin_mode_guard_pkg.sv
package pin_mode_guard_pkg;
    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/pmg_lock_fsm.sv
module pmg_lock_fsm
    import pin_mode_guard_pkg::*;
#(
    parameter int                 KEY_W = 32,
    parameter logic [KEY_W-1:0]   KEY   = 32'hC0DE_5A17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wdata,
    output logic             unlocked
);
    lock_state_e state_q;
    lock_state_e state_d;

    // next-state logic: KEY_MATCH opens, KEY_MISS closes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (wr_en && (wdata == KEY))  state_d = LK_OPEN;
            LK_OPEN:   if (wr_en && (wdata != KEY))  state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN:   unlocked = 1'b1;
            LK_LOCKED: unlocked = 1'b0;
            default:   unlocked = 1'b0;
        endcase
    end

    assert_key_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata == KEY)) |=> (state_q == LK_OPEN));
    assert_miss_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata != KEY)) |=> (state_q == LK_LOCKED));
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));
endmodule

// File: rtl/pmg_commit_reg.sv
module pmg_commit_reg #(
    parameter int               W         = 8,
    parameter logic [W-1:0]     PROT_MASK = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         unlocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] commit_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  commit_q <= '0;
        else if (wr_en && unlocked)  commit_q <= wdata & PROT_MASK;
    end

    assert_locked_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked) |=> $stable(commit_q));
    assert_open_commit_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlocked) |=> ((commit_q & PROT_MASK) == ($past(wdata) & PROT_MASK)));
endmodule

// File: rtl/pmg_select_reg.sv
module pmg_select_reg #(
    parameter int               W         = 8,
    parameter logic [W-1:0]     PROT_MASK = 8'h80,
    parameter logic [W-1:0]     DFLT      = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] allow,
    output logic [W-1:0] sel_q
);
    logic [W-1:0] wmask;
    logic [W-1:0] sel_d;

    always_comb begin
        wmask = ~PROT_MASK | (allow & PROT_MASK);
        sel_d = (wdata & wmask) | (sel_q & ~wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q <= DFLT;
        else if (wr_en) sel_q <= sel_d;
    end

    assert_free_bits_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((sel_q & ~PROT_MASK) == ($past(wdata) & ~PROT_MASK)));
    assert_guarded_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((allow & PROT_MASK) == '0)) |=> ((sel_q & PROT_MASK) == $past(sel_q & PROT_MASK)));
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/pin_mode_guard.sv
module pin_mode_guard #(
    parameter int                  PIN_W      = 8,
    parameter int                  DATA_W     = 32,
    parameter int                  ADDR_W     = 12,
    parameter logic [PIN_W-1:0]    PROT_MASK  = 8'h80,
    parameter logic [PIN_W-1:0]    DFLT_SEL   = 8'h80,
    parameter logic [DATA_W-1:0]   UNLOCK_KEY = 32'hC0DE_5A17,
    parameter logic [ADDR_W-1:0]   SEL_OFS    = 12'h420,
    parameter logic [ADDR_W-1:0]   LOCK_OFS   = 12'h520,
    parameter logic [ADDR_W-1:0]   COMMIT_OFS = 12'h524
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PIN_W-1:0]  sel_out
);
    logic             rst_n;
    logic             hit_sel, hit_lock, hit_commit;
    logic             unlocked;
    logic [PIN_W-1:0] commit_q;
    logic [PIN_W-1:0] allow;
    logic [PIN_W-1:0] sel_q;

    assign rst_n = por_n & ext_rst_n;

    always_comb begin
        hit_sel    = (bus_addr == SEL_OFS);
        hit_lock   = (bus_addr == LOCK_OFS);
        hit_commit = (bus_addr == COMMIT_OFS);
        allow      = unlocked ? commit_q : '0;
    end

    pmg_lock_fsm #(.KEY_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && hit_lock),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    pmg_commit_reg #(.W(PIN_W), .PROT_MASK(PROT_MASK)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && hit_commit),
        .unlocked (unlocked),
        .wdata    (bus_wdata[PIN_W-1:0]),
        .commit_q (commit_q)
    );

    pmg_select_reg #(.W(PIN_W), .PROT_MASK(PROT_MASK), .DFLT(DFLT_SEL)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && hit_sel),
        .wdata (bus_wdata[PIN_W-1:0]),
        .allow (allow),
        .sel_q (sel_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_sel)         bus_rdata[PIN_W-1:0] = sel_q;
        else if (hit_lock)   bus_rdata[0]         = ~unlocked;
        else if (hit_commit) bus_rdata[PIN_W-1:0] = commit_q;
    end

    assign sel_out = sel_q;

    assert_relock_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_sel && !unlocked) |=> ((sel_out & PROT_MASK) == $past(sel_out & PROT_MASK)));
    assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_sel && !hit_lock && !hit_commit) |-> (bus_rdata == '0));
endmodule

// File: tb/pin_mode_guard_tb.sv
module pin_mode_guard_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  sel_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pin_mode_guard u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sel_out   (sel_out)
    );

    localparam logic [31:0] KEY = 32'hC0DE_5A17;
    localparam int NV = 31;
    // fields: op (0 write, 1 read-check), requirement, offset, data or expected value
    localparam logic [48:0] VECS [0:NV-1] = '{
        {1'b1, 4'd1, 12'h420, 32'h80},       // R1 reset mode value
        {1'b1, 4'd1, 12'h520, 32'h1},        // R1 lock closed
        {1'b1, 4'd1, 12'h524, 32'h0},        // R1 commit clear
        {1'b0, 4'd4, 12'h420, 32'h00},       // R4 locked write
        {1'b1, 4'd4, 12'h420, 32'h80},
        {1'b0, 4'd3, 12'h420, 32'h35},       // R3 free bits
        {1'b1, 4'd3, 12'h420, 32'hB5},
        {1'b0, 4'd6, 12'h524, 32'hFF},       // R6 commit refused while locked
        {1'b1, 4'd6, 12'h524, 32'h00},
        {1'b0, 4'd5, 12'h520, KEY},          // R5 open
        {1'b1, 4'd5, 12'h520, 32'h0},
        {1'b0, 4'd4, 12'h420, 32'h00},       // R4 open but no commit
        {1'b1, 4'd4, 12'h420, 32'h80},
        {1'b0, 4'd6, 12'h524, 32'hFF},       // R6 commit masked
        {1'b1, 4'd6, 12'h524, 32'h80},
        {1'b0, 4'd4, 12'h420, 32'h01},       // R4 both guards allow
        {1'b1, 4'd4, 12'h420, 32'h01},
        {1'b0, 4'd4, 12'h420, 32'h81},
        {1'b1, 4'd4, 12'h420, 32'h81},
        {1'b0, 4'd5, 12'h520, 32'h0},        // R5 close
        {1'b1, 4'd5, 12'h520, 32'h1},
        {1'b0, 4'd4, 12'h420, 32'h02},       // R4 relocked, commit still set
        {1'b1, 4'd4, 12'h420, 32'h82},
        {1'b0, 4'd6, 12'h524, 32'h00},       // R6 locked commit write
        {1'b1, 4'd6, 12'h524, 32'h80},
        {1'b1, 4'd7, 12'h000, 32'h0},        // R7 unmapped read
        {1'b0, 4'd7, 12'h428, 32'hFFFF_FFFF},
        {1'b1, 4'd7, 12'h428, 32'h0},
        {1'b1, 4'd7, 12'h420, 32'h82},
        {1'b0, 4'd5, 12'h520, 32'hC0DE_5A18},// R5 near-miss key
        {1'b1, 4'd5, 12'h520, 32'h1}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        #1 check(1, {24'b0, sel_out}, 32'h80);    // R1 sel_out at reset

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][48]) rd_check(int'(VECS[i][47:44]), VECS[i][43:32], VECS[i][31:0]);
            else             wr(VECS[i][43:32], VECS[i][31:0]);
        end

        @(negedge clk); #1 check(2, {24'b0, sel_out}, 32'h82);  // R2 pins follow register

        // R2: all pins to software control with both guards open
        wr(12'h520, KEY);
        wr(12'h420, 32'h0);
        @(negedge clk); #1 check(2, {24'b0, sel_out}, 32'h00);
        rd_check(2, 12'h420, 32'h00);

        // R8: external reset in the same cycle as a mode write
        wr(12'h420, 32'h7F);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h420; bus_wdata = 32'h00;
        ext_rst_n = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check(8, {24'b0, sel_out}, 32'h80);
        ext_rst_n = 1'b1;
        rd_check(8, 12'h520, 32'h1);
        rd_check(8, 12'h524, 32'h0);

        // R8: power-on reset alone restores defaults
        wr(12'h520, KEY);
        wr(12'h524, 32'h80);
        wr(12'h420, 32'h11);
        @(negedge clk); #1 check(8, {24'b0, sel_out}, 32'h11);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        #1 check(8, {24'b0, sel_out}, 32'h80);
        rd_check(8, 12'h520, 32'h1);
        rd_check(8, 12'h524, 32'h0);

        finish_run();
    end
endmodule